// File: doc/BRIEF.md
# Predicated Byte Gather Engine

This block assembles one vector register out of single bytes gathered from memory. A start pulse captures a 64-bit scalar base, a vector of per-element offsets, a predicate with one bit per vector byte, a mode and an extend select. The engine then steps through the elements from index 0 upward. For each active element it forms an address from the base and the extended offset, reads one byte over a request/response memory port, sign-extends that byte to the element width and writes it into the result lane. Inactive elements stay zero and generate no memory traffic.

Both memory channels use valid/ready. The request channel holds `mem_req_valid` and `mem_req_addr` steady until the memory accepts with `mem_req_ready`. The response channel takes a byte only while `mem_rsp_ready` is high, so the memory can stall either side for any number of cycles. Only one read is in flight at any time. Start, busy, done and the stack-alignment strobe are plain control pins.

Top module: `gather_byte_engine`

## Requirements
- R1: Each requested address is the latched base plus the extended offset of that element, modulo 2^64, with no scaling.
- R2: In mode 0 (64-bit elements) and mode 1 (32-bit elements) only the low 32 bits of the element's offset are used. They are zero-extended when `sext_sel` is 0 and sign-extended when it is 1.
- R3: In mode 2 the whole 64-bit offset element is used unsigned and `sext_sel` has no effect. Mode 3 behaves exactly like mode 2.
- R4: The byte returned for an element is sign-extended to the element width, 32 bits in mode 1 and 64 bits otherwise. Element e occupies result bits [e*W +: W].
- R5: An element is active when the predicate bit at its lowest byte, bit e*W/8, is set; the other predicate bits of the element are ignored. An inactive element produces no memory request and its lane reads all zeros.
- R6: Elements are requested in ascending index order with at most one read outstanding. A pending request keeps valid high and its address stable until it is accepted.
- R7: `mem_rsp_ready` is high only after a request has been accepted and before its byte has been taken. It is never high in the same cycle as `mem_req_valid`.
- R8: `start` is accepted only while `busy` is low. `busy` rises in the next cycle, and a `start` seen while busy has no effect on the running operation or its result.
- R9: `done` is a one-cycle pulse in the first cycle that `busy` is low again. `result` holds the assembled vector from then until the next accepted start.
- R10: `sp_align_chk` pulses for one cycle, in the cycle after an accepted start, when `base_is_sp` is set and either at least one element is active or `sp_chk_idle` is set. It stays low in every other cycle.
- R11: The number of elements is VLEN/32 in mode 1 and VLEN/64 in the other modes. No lane beyond that count is written.
- R12: After reset `busy`, `done`, `sp_align_chk`, `mem_req_valid` and `mem_rsp_ready` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; operands captured on this cycle |
| base | input | 64 | Scalar base address |
| base_is_sp | input | 1 | Base comes from the stack pointer |
| offsets | input | VLEN | Offset vector, 32- or 64-bit elements |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| mode | input | 2 | 0: 32b offset/64b element, 1: 32b/32b, 2 or 3: 64b/64b |
| sext_sel | input | 1 | 1 sign-extends 32-bit offsets, 0 zero-extends them |
| sp_chk_idle | input | 1 | Raise the alignment strobe even when no element is active |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | VLEN | Assembled vector |
| sp_align_chk | output | 1 | Stack alignment check strobe |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine accepts read data |
| mem_rsp_data | input | 8 | Returned byte |

## Verification
The assertions assume the memory returns exactly one response for each accepted request and never presents a response before its request has been accepted. They also assume `start` is low during reset. The bench's memory responder holds to this: it raises response valid only for a request it has already accepted, and it varies the ready and response delays from cycle to cycle to exercise stalls on both channels. Every mode and extend setting is swept against all-active, none-active, alternating and random predicates. Offsets have their sign bits set, and memory contents include bytes with the top bit set.

// File: rtl/gbe_pkg.sv
package gbe_pkg;
  typedef enum logic [1:0] {
    GM_O32_E64 = 2'd0,
    GM_O32_E32 = 2'd1,
    GM_O64_E64 = 2'd2,
    GM_O64_ALT = 2'd3
  } gm_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } gbe_state_e;

  function automatic logic mode_is_e32(input logic [1:0] m);
    return m == GM_O32_E32;
  endfunction

  function automatic logic mode_is_o64(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/gbe_elem_pick.sv
module gbe_elem_pick import gbe_pkg::*; #(
  parameter int VLEN = 256,
  localparam int NW = VLEN / 32,
  localparam int ND = VLEN / 64,
  localparam int LW = $clog2(NW),
  localparam int IW = LW + 1
) (
  input  logic [VLEN-1:0]   offs,
  input  logic [VLEN/8-1:0] pmask,
  input  logic [1:0]        mode,
  input  logic              sext_sel,
  input  logic [IW-1:0]     idx,
  output logic              active,
  output logic [63:0]       off_ext
);
  logic [31:0] w32 [NW];
  logic [31:0] dlo [ND];
  logic [31:0] dhi [ND];
  logic        a32 [NW];
  logic        a64 [ND];

  for (genvar w = 0; w < NW; w++) begin : g_w32
    assign w32[w] = offs[w*32 +: 32];
    assign a32[w] = pmask[w*4];
  end

  for (genvar d = 0; d < ND; d++) begin : g_d64
    assign dlo[d] = offs[d*64 +: 32];
    assign dhi[d] = offs[d*64 + 32 +: 32];
    assign a64[d] = pmask[d*8];
  end

  logic        e32, o64;
  logic [31:0] lo, hi;

  always_comb begin
    e32 = mode_is_e32(mode);
    o64 = mode_is_o64(mode);
    lo  = e32 ? w32[idx[LW-1:0]] : dlo[idx[LW-2:0]];
    hi  = dhi[idx[LW-2:0]];
    active = e32 ? a32[idx[LW-1:0]] : a64[idx[LW-2:0]];
    if (o64)
      off_ext = {hi, lo};
    else
      off_ext = {(sext_sel ? {32{lo[31]}} : 32'd0), lo};
  end
endmodule

// File: rtl/gbe_lane_write.sv
module gbe_lane_write #(
  parameter int VLEN = 256,
  localparam int NW = VLEN / 32,
  localparam int ND = VLEN / 64,
  localparam int LW = $clog2(NW),
  localparam int IW = LW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic            e32,
  input  logic [IW-1:0]   idx,
  input  logic [7:0]      byte_in,
  output logic [VLEN-1:0] result
);
  logic [31:0] lo_word, hi_word;
  assign lo_word = {{24{byte_in[7]}}, byte_in};
  assign hi_word = {32{byte_in[7]}};

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic hit;
    logic [31:0] val;
    always_comb begin
      if (e32) begin
        hit = (idx == IW'(w));
        val = lo_word;
      end else begin
        hit = (idx == IW'(w / 2));
        val = (w % 2 == 0) ? lo_word : hi_word;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                result[w*32 +: 32] <= '0;
      else if (clr)              result[w*32 +: 32] <= '0;
      else if (wr_en && hit)     result[w*32 +: 32] <= val;
    end
  end

  // R11
  wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (e32 ? (idx < IW'(NW)) : (idx < IW'(ND))));

  // R11
  wr_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr));
endmodule

// File: rtl/gather_byte_engine.sv
module gather_byte_engine import gbe_pkg::*; #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       base,
  input  logic              base_is_sp,
  input  logic [VLEN-1:0]   offsets,
  input  logic [VLEN/8-1:0] pred,
  input  logic [1:0]        mode,
  input  logic              sext_sel,
  input  logic              sp_chk_idle,
  output logic              busy,
  output logic              done,
  output logic [VLEN-1:0]   result,
  output logic              sp_align_chk,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [7:0]        mem_rsp_data
);
  localparam int NW = VLEN / 32;
  localparam int ND = VLEN / 64;
  localparam int LW = $clog2(NW);
  localparam int IW = LW + 1;

  gbe_state_e          st;
  logic [63:0]         base_q;
  logic [VLEN-1:0]     offs_q;
  logic [VLEN/8-1:0]   pred_q;
  logic [1:0]          mode_q;
  logic                sext_q;
  logic [IW-1:0]       idx;
  logic [IW-1:0]       n_elem;
  logic                e32_q;
  logic                start_acc;
  logic                any_act;
  logic                cur_act;
  logic [63:0]         cur_off;
  logic                at_end;
  logic                wr_en;

  assign e32_q     = mode_is_e32(mode_q);
  assign n_elem    = e32_q ? IW'(NW) : IW'(ND);
  assign start_acc = start && (st == ST_IDLE);
  assign at_end    = (idx == n_elem);
  assign busy      = (st != ST_IDLE);

  // Any active element among the operands presented with start
  always_comb begin
    any_act = 1'b0;
    if (mode_is_e32(mode)) begin
      for (int e = 0; e < NW; e++) any_act = any_act | pred[e*4];
    end else begin
      for (int e = 0; e < ND; e++) any_act = any_act | pred[e*8];
    end
  end

  gbe_elem_pick #(.VLEN(VLEN)) u_pick (
    .offs     (offs_q),
    .pmask    (pred_q),
    .mode     (mode_q),
    .sext_sel (sext_q),
    .idx      (idx),
    .active   (cur_act),
    .off_ext  (cur_off)
  );

  assign mem_req_valid = (st == ST_RUN) && !at_end && cur_act;
  assign mem_req_addr  = base_q + cur_off;
  assign mem_rsp_ready = (st == ST_WAIT);
  assign wr_en         = mem_rsp_ready && mem_rsp_valid;

  gbe_lane_write #(.VLEN(VLEN)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_acc),
    .wr_en   (wr_en),
    .e32     (e32_q),
    .idx     (idx),
    .byte_in (mem_rsp_data),
    .result  (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      base_q       <= '0;
      offs_q       <= '0;
      pred_q       <= '0;
      mode_q       <= '0;
      sext_q       <= 1'b0;
      idx          <= '0;
      done         <= 1'b0;
      sp_align_chk <= 1'b0;
    end else begin
      done         <= 1'b0;
      sp_align_chk <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_acc) begin
            base_q       <= base;
            offs_q       <= offsets;
            pred_q       <= pred;
            mode_q       <= mode;
            sext_q       <= sext_sel;
            idx          <= '0;
            sp_align_chk <= base_is_sp && (any_act || sp_chk_idle);
            st           <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (at_end) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else if (!cur_act) begin
            idx <= idx + 1'b1;
          end else if (mem_req_ready) begin
            st <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            idx <= idx + 1'b1;
            st  <= ST_RUN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (idx != $past(idx))) |-> (idx == $past(idx) + 1'b1));

  // R7
  rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  // R7
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rsp_ready) |-> $past(mem_req_valid && mem_req_ready));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)) ##1 !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(start && !busy)) |-> $stable(result));

  // R10
  sp_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_align_chk |-> ($past(start && !busy) && $past(base_is_sp)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !mem_rsp_ready));
endmodule

// File: tb/gather_byte_engine_tb.sv
`timescale 1ns/1ps
module gather_byte_engine_tb;
  localparam int VLEN = 256;
  localparam int NB = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [63:0]     base = '0;
  logic            base_is_sp = 1'b0;
  logic [VLEN-1:0] offsets = '0;
  logic [NB-1:0]   pred = '0;
  logic [1:0]      mode = '0;
  logic            sext_sel = 1'b0;
  logic            sp_chk_idle = 1'b0;
  logic            busy, done, sp_align_chk;
  logic [VLEN-1:0] result;
  logic            mem_req_valid, mem_rsp_ready;
  logic            mem_req_ready = 1'b0;
  logic [63:0]     mem_req_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [7:0]      mem_rsp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gather_byte_engine #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .base_is_sp(base_is_sp),
    .offsets(offsets), .pred(pred), .mode(mode), .sext_sel(sext_sel),
    .sp_chk_idle(sp_chk_idle), .busy(busy), .done(done), .result(result),
    .sp_align_chk(sp_align_chk), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] mem_byte(input logic [63:0] a);
    return a[7:0] ^ a[23:16] ^ a[63:56] ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: log accepted requests, answer after a variable delay
  logic [63:0] log_addr [16];
  int          log_n = 0;
  logic        pend = 1'b0;
  int          dly = 0;
  logic [7:0]  pend_data = '0;

  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = ($urandom_range(0, 2) != 0);
      if (pend && dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_data;
      end else begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 8'hxx;
        if (pend) dly--;
      end
      #1;
      if (mem_rsp_valid && mem_rsp_ready) pend = 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (log_n < 16) log_addr[log_n] = mem_req_addr;
        log_n++;
        pend      = 1'b1;
        dly       = $urandom_range(0, 2);
        pend_data = mem_byte(mem_req_addr);
      end
    end
  end

  // Run one operation and compare against the arithmetic model
  task automatic run_op(input logic [63:0] b, input logic [VLEN-1:0] o, input logic [NB-1:0] p,
                        input logic [1:0] m, input logic sx, input logic isp, input logic spi,
                        input logic poke);
    logic [VLEN-1:0] exp_res;
    logic [63:0]     exp_addr [16];
    int              exp_n;
    int              w, ne, cyc;
    logic            anyact;
    exp_res = '0; exp_n = 0; anyact = 1'b0;
    w  = (m == 2'd1) ? 32 : 64;
    ne = VLEN / w;
    for (int e = 0; e < ne; e++) begin
      logic [63:0] off;
      logic [7:0]  by;
      if (p[e * w / 8]) begin
        anyact = 1'b1;
        if (m[1]) off = o[e*64 +: 64];
        else begin
          logic [31:0] lo;
          lo  = o[e*w +: 32];
          off = sx ? {{32{lo[31]}}, lo} : {32'd0, lo};
        end
        exp_addr[exp_n] = b + off;
        by = mem_byte(b + off);
        if (w == 32) exp_res[e*32 +: 32] = {{24{by[7]}}, by};
        else         exp_res[e*64 +: 64] = {{56{by[7]}}, by};
        exp_n++;
      end
    end
    @(negedge clk);
    log_n = 0;
    base = b; offsets = o; pred = p; mode = m; sext_sel = sx;
    base_is_sp = isp; sp_chk_idle = spi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8 busy rises the cycle after start; R10 strobe in the same cycle
    check("R8 busy", VLEN'(busy), VLEN'(1));
    check("R10 sp strobe", VLEN'(sp_align_chk), VLEN'(isp && (anyact || spi)));
    if (poke) begin
      // R8 start while busy with different operands must be ignored
      base = ~b; offsets = ~o; pred = ~p; mode = m ^ 2'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R10 no second strobe", VLEN'(sp_align_chk), VLEN'(0));
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (!done && sp_align_chk) check("R10 strobe late", VLEN'(1), VLEN'(0));
    end
    if (cyc >= 2000) check("R9 watchdog", VLEN'(0), VLEN'(1));
    check("R9 busy low at done", VLEN'(busy), VLEN'(0));
    check("R4 R5 R11 result", result, exp_res);
    check("R5 R6 request count", VLEN'(log_n), VLEN'(exp_n));
    for (int k = 0; k < exp_n && k < 16 && k < log_n; k++)
      check("R1 R2 R3 R6 address", VLEN'(log_addr[k]), VLEN'(exp_addr[k]));
    @(negedge clk);
    check("R9 done single cycle", VLEN'(done), VLEN'(0));
    check("R9 result held", result, exp_res);
  endtask

  function automatic logic [VLEN-1:0] mk_offs(input int kind);
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (kind == 0 && k % 2 == 0) r[31] = 1'b1;
      if (kind == 1) r = 32'hFFFF_FF00 - 32'(k * 17);
      v[k*32 +: 32] = r;
    end
    return v;
  endfunction

  initial begin
    #(5.0 * 150000);
    check("R9 global watchdog", VLEN'(0), VLEN'(1));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", VLEN'(busy), VLEN'(0));
    check("R12 done", VLEN'(done), VLEN'(0));
    check("R12 req/rsp", VLEN'({mem_req_valid, mem_rsp_ready, sp_align_chk}), VLEN'(0));
    check("R12 result", result, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      for (int sx = 0; sx < 2; sx++) begin
        for (int pk = 0; pk < 6; pk++) begin
          logic [NB-1:0] p;
          case (pk)
            0: p = '1;
            1: p = '0;
            2: p = {(NB/4){4'b0101}};
            3: p = {(NB/2){2'b10}};
            default: p = NB'($urandom);
          endcase
          run_op({$urandom, $urandom}, mk_offs(pk % 2), p, 2'(m), 1'(sx),
                 1'(pk % 3 == 0), 1'(pk % 2), 1'(pk == 4));
        end
      end
    end
    // R5 only the lowest predicate bit of each element counts
    run_op(64'h0000_1000_0000_0000, mk_offs(0), {(NB/8){8'hFE}}, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_op(64'h8000_0000_0000_0010, mk_offs(1), {(NB/4){4'hE}}, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
    // R3 sext_sel ignored in 64-bit offset mode with negative offsets
    run_op(64'h0123_4567_89AB_CDEF, mk_offs(1), '1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1);
    run_op(64'h0123_4567_89AB_CDEF, mk_offs(1), '1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule